// File: doc/BRIEF.md
# Flash Embedded-Operation Status Word Generator

This block builds the word a NOR flash presents on its data bus while an internal program or erase algorithm is running, and hands the bus back to true array data once that algorithm is finished. Command decoding, the array itself and analog timing are outside the block. It receives the following inputs:

- a busy indication;
- the kind of running operation;
- bit 7 of the data being programmed;
- a time-limit-exceeded flag;
- a flag that says the sector-erase acceptance window is still open;
- a read strobe;
- the array data word.

Inside the status word, the poll bit is at position 7, the toggle bit at position 6, the time-limit bit at position 5 and the erase-window bit at position 3. The toggle bit changes once per read access, not once per clock. It advances on each rising edge of the read strobe, so consecutive reads see alternating values.

A ready output is low while an algorithm runs. When a hardware reset request arrives during an operation, ready also stays low for a fixed recovery interval after the request.

Top module: `flash_stat_gen`

## Requirements
- R1: When `busy_i` is 0, `dout_o` equals `array_i` in the same cycle.
- R2: While busy with `op_i` = 2'b00 (program), `dout_o[7]` is the inverse of `prog_bit7_i`.
- R3: While busy with any nonzero `op_i` (01 sector erase, 10 chip erase, 11 treated as erase), `dout_o[7]` is 0.
- R4: A rising edge of `rd_i` (high now, low in the previous cycle) seen at a clock edge while `busy_i` is 1 inverts `dout_o[6]` from the next cycle on. Without such an edge the bit holds its value.
- R5: While busy, `dout_o[5]` equals `tmo_i`.
- R6: While busy with `op_i` = 2'b01, `dout_o[3]` is the inverse of `win_open_i`. While busy with any other `op_i`, it is 0.
- R7: While busy, every bit of `dout_o` other than 7, 6, 5 and 3 is 0.
- R8: `rdy_o` is 0 in every cycle in which `busy_i` is 1.
- R9: A clock edge at which `hw_rst_i` and `busy_i` are both 1 forces `rdy_o` to 0 for the following `RST_CYCLES` cycles, whatever `busy_i` does. `hw_rst_i` has no effect while `busy_i` is 0.
- R10: After `rst`, the toggle bit reads 0, no recovery interval is pending, and `rdy_o` equals the inverse of `busy_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Internal algorithm running |
| op_i | input | 2 | Operation kind: 00 program, 01 sector erase, 10 chip erase |
| prog_bit7_i | input | 1 | Bit 7 of the data being programmed |
| tmo_i | input | 1 | Operation exceeded its time limit |
| win_open_i | input | 1 | Sector-erase acceptance window still open |
| rd_i | input | 1 | Read strobe |
| hw_rst_i | input | 1 | Hardware reset request |
| array_i | input | DW | True array data |
| dout_o | output | DW | Data bus word (status while busy, array data otherwise) |
| rdy_o | output | 1 | Ready (1) / busy (0) |

## Verification
Several properties are checked on every cycle by the assertions:

- the toggle bit flips exactly on a qualified strobe edge and holds otherwise;
- ready is low whenever busy is high;
- a reset request during an operation loads the recovery interval, and that interval then counts down one step per cycle;
- the erase-window bit and the program poll bit follow their inputs.

Some behaviour can only be shown by the bench's scenarios, which compare against a behavioural model on every clock:

- the full length of the recovery window after busy drops;
- that a strobe held high advances the toggle bit only once;
- that reset requests while idle change nothing;
- the return to array data at completion.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SECT = 2'b01,
        OP_CHIP = 2'b10,
        OP_RSVD = 2'b11
    } op_kind_e;

    typedef struct packed {
        logic poll;
        logic tog;
        logic tmo;
        logic win;
    } stat_bits_t;

    localparam int POLL_POS = 7;
    localparam int TOG_POS  = 6;
    localparam int TMO_POS  = 5;
    localparam int WIN_POS  = 3;

    function automatic stat_bits_t make_status(op_kind_e op, logic bit7,
                                               logic tog, logic tmo,
                                               logic win_open);
        stat_bits_t s;
        s.poll = (op == OP_PROG) ? ~bit7 : 1'b0;
        s.tog  = tog;
        s.tmo  = tmo;
        s.win  = (op == OP_SECT) ? ~win_open : 1'b0;
        return s;
    endfunction

    function automatic logic [7:0] place_status(stat_bits_t s);
        logic [7:0] b;
        b = '0;
        b[POLL_POS] = s.poll;
        b[TOG_POS]  = s.tog;
        b[TMO_POS]  = s.tmo;
        b[WIN_POS]  = s.win;
        return b;
    endfunction

endpackage

// File: rtl/stat_toggle.sv
module stat_toggle (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    input  logic rd_i,
    output logic tog_o
);
    logic rd_q;
    logic tog_q;
    logic rd_rise;

    assign rd_rise = rd_i & ~rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= 1'b0;
            tog_q <= 1'b0;
        end else begin
            rd_q <= rd_i;
            if (busy_i && rd_rise)
                tog_q <= ~tog_q;
        end
    end

    assign tog_o = tog_q;

    // R4
    tog_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && rd_i && !rd_q) |=> (tog_q != $past(tog_q)));

    // R4
    tog_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy_i && rd_i && !rd_q) |=> $stable(tog_q));

endmodule

// File: rtl/stat_recover.sv
module stat_recover #(
    parameter int RST_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    input  logic hw_rst_i,
    output logic rdy_o
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(RST_CYCLES);

    logic [CW-1:0] cnt_q;
    logic          load;

    assign load = hw_rst_i & busy_i;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign rdy_o = ~busy_i & (cnt_q == '0);

    // R9
    rec_load_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_rst_i && busy_i) |=> (cnt_q == LOAD_VAL));

    // R9
    rec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && !(hw_rst_i && busy_i)) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/stat_word_mux.sv
module stat_word_mux
    import flash_stat_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          busy_i,
    input  stat_bits_t    stat_i,
    input  logic [DW-1:0] array_i,
    output logic [DW-1:0] dout_o
);
    logic [DW-1:0] stat_word;

    always_comb begin
        stat_word      = '0;
        stat_word[7:0] = place_status(stat_i);
    end

    assign dout_o = busy_i ? stat_word : array_i;

endmodule

// File: rtl/flash_stat_gen.sv
module flash_stat_gen
    import flash_stat_pkg::*;
#(
    parameter int DW         = 16,
    parameter int RST_CYCLES = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy_i,
    input  logic [1:0]    op_i,
    input  logic          prog_bit7_i,
    input  logic          tmo_i,
    input  logic          win_open_i,
    input  logic          rd_i,
    input  logic          hw_rst_i,
    input  logic [DW-1:0] array_i,
    output logic [DW-1:0] dout_o,
    output logic          rdy_o
);
    logic       tog;
    stat_bits_t stat;
    op_kind_e   op;

    assign op = op_kind_e'(op_i);

    stat_toggle u_tog (
        .clk    (clk),
        .rst    (rst),
        .busy_i (busy_i),
        .rd_i   (rd_i),
        .tog_o  (tog)
    );

    stat_recover #(.RST_CYCLES(RST_CYCLES)) u_rec (
        .clk      (clk),
        .rst      (rst),
        .busy_i   (busy_i),
        .hw_rst_i (hw_rst_i),
        .rdy_o    (rdy_o)
    );

    assign stat = make_status(op, prog_bit7_i, tog, tmo_i, win_open_i);

    stat_word_mux #(.DW(DW)) u_mux (
        .busy_i  (busy_i),
        .stat_i  (stat),
        .array_i (array_i),
        .dout_o  (dout_o)
    );

    // R8
    busy_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> !rdy_o);

    // R9
    hwrst_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_rst_i && busy_i) |=> !rdy_o);

    // R2
    poll_prog_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && op_i == 2'b00) |-> (dout_o[7] == !prog_bit7_i));

    // R6
    win_sect_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && op_i == 2'b01) |-> (dout_o[3] == !win_open_i));

endmodule

// File: tb/flash_stat_gen_tb.sv
module flash_stat_gen_tb_top;
    localparam int PERIOD = 10;
    localparam int DW     = 16;
    localparam int RSTN   = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          busy = 1'b0, b7 = 1'b0, tmo = 1'b0, win = 1'b0;
    logic          rd = 1'b0, hw = 1'b0;
    logic [1:0]    op = 2'b00;
    logic [DW-1:0] arr = '0;
    logic [DW-1:0] dout;
    logic          rdy;

    int total = 0, bad = 0;
    bit finished = 0;

    // behavioural reference state
    bit m_tog = 0, m_prev = 0;
    int m_cnt = 0;

    always #(PERIOD/2) clk = ~clk;

    flash_stat_gen #(.DW(DW), .RST_CYCLES(RSTN)) dut_i (
        .clk(clk), .rst(rst), .busy_i(busy), .op_i(op), .prog_bit7_i(b7),
        .tmo_i(tmo), .win_open_i(win), .rd_i(rd), .hw_rst_i(hw),
        .array_i(arr), .dout_o(dout), .rdy_o(rdy));

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_tog = 0; m_prev = 0; m_cnt = 0;
        end else begin
            if (busy && rd && !m_prev) m_tog = !m_tog;
            m_prev = rd;
            if (hw && busy) m_cnt = RSTN;
            else if (m_cnt > 0) m_cnt--;
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (busy) begin
                chk("R8 rdy", int'(rdy), 0);
                if (op == 2'b00) chk("R2 poll", int'(dout[7]), int'(!b7));
                else             chk("R3 poll", int'(dout[7]), 0);
                chk("R4 toggle", int'(dout[6]), int'(m_tog));
                chk("R5 timeout", int'(dout[5]), int'(tmo));
                if (op == 2'b01) chk("R6 window", int'(dout[3]), int'(!win));
                else             chk("R6 window", int'(dout[3]), 0);
                chk("R7 others", int'(dout & ~16'h00E8), 0);
            end else begin
                chk("R1 array", int'(dout), int'(arr));
                if (m_cnt > 0) chk("R9 recovery", int'(rdy), 0);
                else           chk("R9 ready", int'(rdy), 1);
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic reads(int n);
        repeat (n) begin
            rd = 1'b1; arr = DW'($urandom); tick();
            rd = 1'b0; tick();
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        busy = 1'b1; op = 2'b00; b7 = 1'b1;
        #1;
        chk("R10 toggle after reset", int'(dout[6]), 0);
        chk("R10 rdy busy", int'(rdy), 0);
        busy = 1'b0; #1;
        chk("R10 rdy idle", int'(rdy), 1);
        tick();
        // idle passthrough, strobes ignored
        for (int i = 0; i < 20; i++) begin
            arr = DW'($urandom); rd = i[0]; tick();
        end
        // program, back-to-back reads
        busy = 1'b1; op = 2'b00; b7 = 1'b0; rd = 1'b0; tick();
        reads(6);
        b7 = 1'b1; reads(5);
        // strobe held high: one edge only
        rd = 1'b1; tick(6); rd = 1'b0; tick(2);
        // timeout during program
        tmo = 1'b1; reads(3); tmo = 1'b0;
        busy = 1'b0; tick(4);
        // sector erase, window open then closed
        busy = 1'b1; op = 2'b01; win = 1'b1; reads(4);
        win = 1'b0; reads(4);
        tmo = 1'b1; reads(2); tmo = 1'b0;
        busy = 1'b0; tick(3);
        // chip erase and reserved code
        busy = 1'b1; op = 2'b10; win = 1'b1; reads(4);
        op = 2'b11; reads(2);
        busy = 1'b0; tick(2);
        // hw reset while idle: no effect
        hw = 1'b1; tick(3); hw = 1'b0; tick(2);
        // hw reset during erase, busy drops immediately
        busy = 1'b1; op = 2'b01; reads(2);
        hw = 1'b1; tick(); hw = 1'b0; busy = 1'b0;
        tick(RSTN + 5);
        // repeated hw reset requests during program
        busy = 1'b1; op = 2'b00; hw = 1'b1; tick(3); hw = 1'b0; tick(4);
        busy = 1'b0; tick(RSTN + 5);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            busy = ($urandom % 4) != 0;
            if (($urandom % 16) == 0) op = 2'($urandom);
            b7 = 1'($urandom); tmo = (($urandom % 8) == 0);
            win = 1'($urandom); rd = 1'($urandom);
            hw = (($urandom % 64) == 0);
            arr = DW'($urandom);
            tick();
        end
        busy = 1'b0; hw = 1'b0; rd = 1'b0; tick(RSTN + 3);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule